// File: doc/BRIEF.md
# Boundary-Scan Pin Cell Chain

This block is the data-register side of a boundary-scan path for a group of bidirectional port pins. Each pin has four scan cells: pull-up disable, output enable, output data and sampled pad input. An external TAP controller drives the scan clock and the capture, shift and update strobes, and supplies the current 4-bit instruction. On a capture strobe the cells load the present core and pad values. On shift strobes the cells form one serial register between the serial input and the serial output. On an update strobe the three output-side cells copy their contents into hold latches on the falling clock edge.

While the instruction equals the external-test code, the hold latches drive the pull-up, enable and data lines of every pad. The switch happens in the same cycle the instruction takes that value, with no update strobe needed. Under any other instruction the pads follow the core's own signals, and the chain can still capture and shift without disturbing them. The TAP controller itself is not part of this block; its test-logic-reset state reaches the block as the synchronous reset.

Top module: `bscan_pin_chain`

## Requirements
- R1: A synchronous reset (high at a rising clock edge, held for at least two cycles) clears every scan cell to 0 and clears every hold latch to 0. After reset, the serial output reads 0, and under external test all pad controls read 0.
- R2: The chain shifts least-significant bit first. The serial output always presents chain bit 0. Each rising edge with the shift strobe high moves every bit one place toward bit 0 and loads the serial input into the top bit, NUM_PINS*4-1.
- R3: A rising edge with the capture strobe high loads chain bit 4p with core pull-up disable of pin p, bit 4p+1 with core output enable, bit 4p+2 with core output data, and bit 4p+3 with the pad input of pin p. Pin 0 therefore sits nearest the serial output.
- R4: On a falling clock edge with the update strobe high, the hold latches of pin p load chain bits 4p (pull-up disable), 4p+1 (enable) and 4p+2 (data).
- R5: While the instruction equals EXTEST_CODE (default 4'h0), the pad pull-up disable, enable and data lines of each pin equal that pin's hold latches. This holds immediately, with no update strobe, and regardless of the core signals.
- R6: For every other instruction value, the pad pull-up disable, enable and data lines equal the core's corresponding signals.
- R7: Capture and shift operations without an update strobe leave the hold latches unchanged, so the pad values under external test do not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst | input | 1 | Synchronous active-high reset (TAP test-logic-reset) |
| ir_code | input | IR_W | Current instruction from the TAP |
| tdi | input | 1 | Serial scan input |
| capture_dr | input | 1 | Capture strobe |
| shift_dr | input | 1 | Shift strobe |
| update_dr | input | 1 | Update strobe, acted on at the falling edge |
| tdo | output | 1 | Serial scan output (chain bit 0) |
| core_pud | input | NUM_PINS | Core pull-up disable per pin |
| core_oe | input | NUM_PINS | Core output enable per pin |
| core_out | input | NUM_PINS | Core output data per pin |
| pad_in | input | NUM_PINS | Level seen at each pad |
| pad_pud | output | NUM_PINS | Pull-up disable driven to each pad |
| pad_oe | output | NUM_PINS | Output enable driven to each pad |
| pad_out | output | NUM_PINS | Output data driven to each pad |

## Verification
The checker watches four behaviours on every rising edge. A shift moves chain bit 1 onto the serial output. A capture lands the core and pad values at both ends of the chain. The pad lines follow the latches under external test and follow the core under any other instruction. The latches stay put in every cycle without an update strobe. The bench scenarios cover what a single-edge property cannot show: the full bit map of a capture across sixteen input patterns, a complete serial round trip of arbitrary vectors, a sweep of all fifteen non-test instruction codes, the immediate takeover of the pads when the instruction becomes the test code, and clearing by a reset that arrives mid-operation.

// File: rtl/bscan_pkg.sv
`timescale 1ns/1ps
package bscan_pkg;
  // cells contributed by each pin, in order from the serial output side
  localparam int CELLS_PER_PIN = 4;
  localparam int OFS_PUD = 0;
  localparam int OFS_OE  = 1;
  localparam int OFS_OUT = 2;
  localparam int OFS_IN  = 3;
  // only the output-side cells own a hold latch
  localparam int HOLD_PER_PIN = 3;
endpackage

// File: rtl/bscan_cell.sv
`timescale 1ns/1ps
module bscan_cell (
  input  logic clk,
  input  logic rst,
  input  logic cap_en,
  input  logic shift_en,
  input  logic cap_d,
  input  logic ser_in,
  output logic stage_q
);
  always_ff @(posedge clk) begin
    if (rst)           stage_q <= 1'b0;
    else if (cap_en)   stage_q <= cap_d;
    else if (shift_en) stage_q <= ser_in;
  end
endmodule

// File: rtl/bscan_hold_latch.sv
`timescale 1ns/1ps
module bscan_hold_latch (
  input  logic clk,
  input  logic rst,
  input  logic upd_en,
  input  logic d,
  output logic q
);
  // loads on the falling edge so the value is stable before the next rising edge
  always_ff @(negedge clk) begin
    if (rst)         q <= 1'b0;
    else if (upd_en) q <= d;
  end
endmodule

// File: rtl/bscan_pin_slice.sv
`timescale 1ns/1ps
module bscan_pin_slice
  import bscan_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cap_en,
  input  logic                     shift_en,
  input  logic                     upd_en,
  input  logic                     extest_en,
  input  logic                     ser_in,
  input  logic                     core_pud,
  input  logic                     core_oe,
  input  logic                     core_out,
  input  logic                     pad_in,
  output logic [CELLS_PER_PIN-1:0] cell_q,
  output logic [HOLD_PER_PIN-1:0]  hold_q,
  output logic                     pad_pud,
  output logic                     pad_oe,
  output logic                     pad_out
);
  logic [CELLS_PER_PIN-1:0] cap_vec;
  logic [CELLS_PER_PIN-1:0] nxt_in;

  always_comb begin
    cap_vec          = '0;
    cap_vec[OFS_PUD] = core_pud;
    cap_vec[OFS_OE]  = core_oe;
    cap_vec[OFS_OUT] = core_out;
    cap_vec[OFS_IN]  = pad_in;
  end

  for (genvar k = 0; k < CELLS_PER_PIN; k++) begin : g_cell
    if (k == CELLS_PER_PIN - 1) begin : g_top
      assign nxt_in[k] = ser_in;
    end else begin : g_mid
      assign nxt_in[k] = cell_q[k+1];
    end
    bscan_cell cell_i (
      .clk      (clk),
      .rst      (rst),
      .cap_en   (cap_en),
      .shift_en (shift_en),
      .cap_d    (cap_vec[k]),
      .ser_in   (nxt_in[k]),
      .stage_q  (cell_q[k])
    );
  end

  for (genvar k = 0; k < HOLD_PER_PIN; k++) begin : g_hold
    bscan_hold_latch hold_i (
      .clk    (clk),
      .rst    (rst),
      .upd_en (upd_en),
      .d      (cell_q[k]),
      .q      (hold_q[k])
    );
  end

  // no register here: the pads must switch in the cycle the instruction changes
  always_comb begin
    pad_pud = extest_en ? hold_q[OFS_PUD] : core_pud;
    pad_oe  = extest_en ? hold_q[OFS_OE]  : core_oe;
    pad_out = extest_en ? hold_q[OFS_OUT] : core_out;
  end
endmodule

// File: rtl/bscan_pin_chain.sv
`timescale 1ns/1ps
module bscan_pin_chain
  import bscan_pkg::*;
#(
  parameter int              NUM_PINS    = 8,
  parameter int              IR_W        = 4,
  parameter logic [IR_W-1:0] EXTEST_CODE = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [IR_W-1:0]     ir_code,
  input  logic                tdi,
  input  logic                capture_dr,
  input  logic                shift_dr,
  input  logic                update_dr,
  output logic                tdo,
  input  logic [NUM_PINS-1:0] core_pud,
  input  logic [NUM_PINS-1:0] core_oe,
  input  logic [NUM_PINS-1:0] core_out,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_pud,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] pad_out
);
  localparam int CHAIN_LEN = NUM_PINS * CELLS_PER_PIN;

  logic [CHAIN_LEN-1:0] chain_q;
  logic [NUM_PINS-1:0]  lat_pud;
  logic [NUM_PINS-1:0]  lat_oe;
  logic [NUM_PINS-1:0]  lat_out;
  logic [NUM_PINS-1:0]  slice_sin;
  logic                 extest_en;

  assign extest_en = (ir_code == EXTEST_CODE);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [HOLD_PER_PIN-1:0] hold_v;

    if (p == NUM_PINS - 1) begin : g_last
      assign slice_sin[p] = tdi;
    end else begin : g_inner
      assign slice_sin[p] = chain_q[CELLS_PER_PIN*(p+1)];
    end

    bscan_pin_slice slice_i (
      .clk       (clk),
      .rst       (rst),
      .cap_en    (capture_dr),
      .shift_en  (shift_dr),
      .upd_en    (update_dr),
      .extest_en (extest_en),
      .ser_in    (slice_sin[p]),
      .core_pud  (core_pud[p]),
      .core_oe   (core_oe[p]),
      .core_out  (core_out[p]),
      .pad_in    (pad_in[p]),
      .cell_q    (chain_q[CELLS_PER_PIN*p +: CELLS_PER_PIN]),
      .hold_q    (hold_v),
      .pad_pud   (pad_pud[p]),
      .pad_oe    (pad_oe[p]),
      .pad_out   (pad_out[p])
    );

    assign lat_pud[p] = hold_v[OFS_PUD];
    assign lat_oe[p]  = hold_v[OFS_OE];
    assign lat_out[p] = hold_v[OFS_OUT];
  end

  assign tdo = chain_q[0];
endmodule

// File: rtl/bscan_pin_chain_chk.sv
`timescale 1ns/1ps
module bscan_pin_chain_chk #(
  parameter int              NUM_PINS    = 8,
  parameter int              IR_W        = 4,
  parameter logic [IR_W-1:0] EXTEST_CODE = '0,
  parameter int              CHAIN_LEN   = NUM_PINS * 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic [IR_W-1:0]      ir_code,
  input logic                 capture_dr,
  input logic                 shift_dr,
  input logic                 update_dr,
  input logic                 tdo,
  input logic [NUM_PINS-1:0]  core_pud,
  input logic [NUM_PINS-1:0]  core_oe,
  input logic [NUM_PINS-1:0]  core_out,
  input logic [NUM_PINS-1:0]  pad_in,
  input logic [NUM_PINS-1:0]  pad_pud,
  input logic [NUM_PINS-1:0]  pad_oe,
  input logic [NUM_PINS-1:0]  pad_out,
  input logic [CHAIN_LEN-1:0] chain_q,
  input logic [NUM_PINS-1:0]  lat_pud,
  input logic [NUM_PINS-1:0]  lat_oe,
  input logic [NUM_PINS-1:0]  lat_out
);
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (chain_q == '0 && lat_pud == '0 && lat_oe == '0 && lat_out == '0));

  p_shift_step_r2: assert property (@(posedge clk) disable iff (rst)
    (shift_dr && !capture_dr) |=> (tdo == $past(chain_q[1])));

  p_capture_ends_r3: assert property (@(posedge clk) disable iff (rst)
    capture_dr |=> (tdo == $past(core_pud[0]) &&
                    chain_q[CHAIN_LEN-1] == $past(pad_in[NUM_PINS-1])));

  p_extest_pads_r5: assert property (@(posedge clk) disable iff (rst)
    (ir_code == EXTEST_CODE) |-> (pad_pud == lat_pud && pad_oe == lat_oe && pad_out == lat_out));

  p_core_pads_r6: assert property (@(posedge clk) disable iff (rst)
    (ir_code != EXTEST_CODE) |-> (pad_pud == core_pud && pad_oe == core_oe && pad_out == core_out));

  p_latch_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!update_dr && !$past(update_dr) && !$past(rst)) |->
      ($stable(lat_pud) && $stable(lat_oe) && $stable(lat_out)));
endmodule

bind bscan_pin_chain bscan_pin_chain_chk #(
  .NUM_PINS    (NUM_PINS),
  .IR_W        (IR_W),
  .EXTEST_CODE (EXTEST_CODE),
  .CHAIN_LEN   (CHAIN_LEN)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .ir_code    (ir_code),
  .capture_dr (capture_dr),
  .shift_dr   (shift_dr),
  .update_dr  (update_dr),
  .tdo        (tdo),
  .core_pud   (core_pud),
  .core_oe    (core_oe),
  .core_out   (core_out),
  .pad_in     (pad_in),
  .pad_pud    (pad_pud),
  .pad_oe     (pad_oe),
  .pad_out    (pad_out),
  .chain_q    (chain_q),
  .lat_pud    (lat_pud),
  .lat_oe     (lat_oe),
  .lat_out    (lat_out)
);

// File: tb/bscan_pin_chain_tb_top.sv
`timescale 1ns/1ps
module bscan_pin_chain_tb_top;
  localparam int NP = 4;
  localparam int L  = NP * 4;

  logic          clk = 1'b0;
  logic          rst;
  logic [3:0]    ir_code;
  logic          tdi, capture_dr, shift_dr, update_dr;
  logic          tdo;
  logic [NP-1:0] core_pud, core_oe, core_out, pad_in;
  logic [NP-1:0] pad_pud, pad_oe, pad_out;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  bscan_pin_chain #(.NUM_PINS(NP), .IR_W(4), .EXTEST_CODE(4'h0)) dut_i (
    .clk(clk), .rst(rst), .ir_code(ir_code), .tdi(tdi),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .tdo(tdo), .core_pud(core_pud), .core_oe(core_oe), .core_out(core_out),
    .pad_in(pad_in), .pad_pud(pad_pud), .pad_oe(pad_oe), .pad_out(pad_out)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // expected pad word {pud, oe, out} from a shifted vector
  function automatic logic [3*NP-1:0] lat_exp(input logic [L-1:0] v);
    logic [NP-1:0] a, b, c;
    for (int p = 0; p < NP; p++) begin
      a[p] = v[4*p];
      b[p] = v[4*p+1];
      c[p] = v[4*p+2];
    end
    return {a, b, c};
  endfunction

  function automatic logic [L-1:0] cap_exp();
    logic [L-1:0] e;
    for (int p = 0; p < NP; p++) begin
      e[4*p]   = core_pud[p];
      e[4*p+1] = core_oe[p];
      e[4*p+2] = core_out[p];
      e[4*p+3] = pad_in[p];
    end
    return e;
  endfunction

  function automatic logic [3*NP-1:0] pads();
    return {pad_pud, pad_oe, pad_out};
  endfunction

  // all tasks start and end 1 ns after a rising edge
  task automatic scan(input logic [L-1:0] vin, output logic [L-1:0] vout);
    shift_dr = 1'b1;
    for (int i = 0; i < L; i++) begin
      tdi = vin[i];
      #2 vout[i] = tdo;
      @(posedge clk); #1;
    end
    shift_dr = 1'b0;
  endtask

  task automatic do_capture();
    capture_dr = 1'b1;
    @(posedge clk); #1;
    capture_dr = 1'b0;
  endtask

  task automatic do_update();
    update_dr = 1'b1;
    @(posedge clk); #1;
    update_dr = 1'b0;
  endtask

  task automatic set_core(input int s);
    core_pud = NP'(s);
    core_oe  = NP'(~s);
    core_out = NP'(s * 5 + 2);
    pad_in   = NP'(s * 3 + 1);
  endtask

  initial begin
    #(4 * 150000);
    $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
    total++; bad++;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [L-1:0] got;
    logic [L-1:0] exp_v;
    logic [L-1:0] v1, v2;

    rst = 1'b1; ir_code = 4'h1; tdi = 1'b0;
    capture_dr = 1'b0; shift_dr = 1'b0; update_dr = 1'b0;
    set_core(9);
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1: cleared state
    #1 chk(tdo == 1'b0, "R1 tdo after reset", 32'(tdo), 0);
    ir_code = 4'h0;
    #1 chk(pads() == '0, "R1 latches after reset", 32'(pads()), 0);
    ir_code = 4'h1;
    @(posedge clk); #1;
    scan('0, got);
    chk(got == '0, "R1 chain after reset", 32'(got), 0);

    // R3 capture map and R2 serial round trip over 16 core patterns
    for (int s = 0; s < 16; s++) begin
      set_core(s);
      do_capture();
      exp_v = cap_exp();
      v1 = L'(32'h9E37 * (s + 1));
      scan(v1, got);
      chk(got == exp_v, "R3 capture map", 32'(got), 32'(exp_v));
      scan('0, got);
      chk(got == v1, "R2 shift round trip", 32'(got), 32'(v1));
    end

    // load latches while not in external test
    v1 = 16'hA5C3;
    scan(v1, got);
    do_update();

    // R6: every non-test instruction passes the core through
    for (int c = 1; c < 16; c++) begin
      ir_code = 4'(c);
      set_core(c * 7);
      #1 chk(pads() == {core_pud, core_oe, core_out}, "R6 core passthrough",
             32'(pads()), 32'({core_pud, core_oe, core_out}));
    end

    // R5: latches take the pads at once, core ignored
    ir_code = 4'h0;
    #1 chk(pads() == lat_exp(v1), "R5 immediate takeover", 32'(pads()), 32'(lat_exp(v1)));
    set_core(5);
    #1 chk(pads() == lat_exp(v1), "R5 core ignored", 32'(pads()), 32'(lat_exp(v1)));
    @(posedge clk); #1;

    // R7: shift and capture under external test leave pads alone
    v2 = 16'h3C96;
    scan(v2, got);
    chk(pads() == lat_exp(v1), "R7 shift holds pads", 32'(pads()), 32'(lat_exp(v1)));
    do_capture();
    chk(pads() == lat_exp(v1), "R7 capture holds pads", 32'(pads()), 32'(lat_exp(v1)));
    scan(v2, got);

    // R4: update moves the new vector to the pads
    do_update();
    chk(pads() == lat_exp(v2), "R4 update loads latches", 32'(pads()), 32'(lat_exp(v2)));
    ir_code = 4'h3;
    #1 chk(pads() == {core_pud, core_oe, core_out}, "R6 leave test",
           32'(pads()), 32'({core_pud, core_oe, core_out}));
    ir_code = 4'h0;
    #1 chk(pads() == lat_exp(v2), "R5 reenter test", 32'(pads()), 32'(lat_exp(v2)));

    // R1: reset in the middle clears latches
    @(posedge clk); #1 rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    #1 chk(pads() == '0, "R1 mid reset", 32'(pads()), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule